// File: doc/BRIEF.md
# Packet FIFO Fill and Transmit-Start Controller

This block sits beside the byte FIFO of a packet radio baseband. It decides when the FIFO takes in received bytes and when a transmission may begin. On the receive side, filling starts in one of two ways. In automatic fill, it starts by itself once a sync word has been found. In manual fill, software turns filling on and off through a control bit. A status bit shows that a sync-triggered fill is in progress. Software clears it by writing one, unless a hold input blocks the clear.

On the transmit side, the block watches the FIFO level and the full and empty flags. It issues a one-cycle start strobe once the condition chosen by the data mode and a select bit is met. It then waits for the serializer to report that the last bit has left the shift register, and passes that report on as a one-cycle done interrupt. It also chooses which FIFO flag drives interrupt line 0. The data mode, select and threshold are taken live while the transmitter is idle and are held from the moment a transmission starts until it ends.

Fill state machine: `F_ARMED` (waiting for a sync word), `F_SYNC_FILL` (filling after a sync word), `F_MAN_STOP` and `F_MAN_RUN` (manual method, stopped or filling). Its transitions are:
- arm-to-fill on a sync pulse;
- fill-to-arm on an accepted clear;
- arm-to-manual when the manual method is selected;
- manual stop/run on the control bit;
- manual-to-arm when the automatic method is selected while stopped.

Transmit state machine: `T_IDLE` and `T_SEND`. Its transitions are:
- start: idle to send when enabled and the start condition holds;
- finish: send to idle when the shift-done pulse arrives.

Top module: `pkt_fifo_ctl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, fill_en_o, fill_stat_o, tx_start_o and tx_done_o are 0. With mode 00, irq0_o is also 0.
- R2: With fill_manual_i=0, a sync_det_i pulse in the armed state sets fill_en_o and fill_stat_o one cycle later.
- R3: A fill_clr_i pulse with clr_hold_i=0 and no sync pulse drops fill_stat_o and fill_en_o one cycle later. Filling then waits for a new sync pulse.
- R4: A fill_clr_i pulse in the same cycle as a sync_det_i pulse leaves fill_stat_o set.
- R5: A fill_clr_i pulse while clr_hold_i=1 leaves fill_stat_o set.
- R6: With fill_manual_i=1, the armed state moves to manual. There fill_en_o follows fill_run_i with one cycle of delay, sync_det_i has no effect, and fill_stat_o stays 0.
- R7: A change of fill_manual_i during a sync-triggered fill has no effect until that fill has been cleared.
- R8: In buffered mode (mode_i=01), transmission starts when fifo_full_i=1 if tx_sel_i=0, or when fifo_empty_i=0 if tx_sel_i=1. In both cases irq0_o equals the inverse of fifo_empty_i.
- R9: In packet mode (mode_i=1x), transmission starts when fifo_empty_i=0 if tx_sel_i=0, or when fifo_level_i>=thresh_i if tx_sel_i=1. irq0_o is the threshold flag when tx_sel_i=1 and the inverse of fifo_empty_i otherwise.
- R10: With mode_i=00, no transmission starts and irq0_o is 0.
- R11: tx_start_o is a one-cycle pulse one cycle after the start condition is seen while idle and tx_en_i=1. No further pulse comes before shift_done_i. tx_done_o pulses one cycle after shift_done_i while sending.
- R12: Changes to mode_i, tx_sel_i and thresh_i made while sending do not affect irq0_o until the block is back in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_det_i | input | 1 | Sync word found pulse |
| fill_manual_i | input | 1 | Fill method: 0 automatic, 1 manual |
| fill_run_i | input | 1 | Manual fill control: 1 fill, 0 stop |
| fill_clr_i | input | 1 | Write-one-to-clear pulse for the fill status |
| clr_hold_i | input | 1 | Blocks the fill status clear when 1 |
| mode_i | input | 2 | Data mode: 00 continuous, 01 buffered, 1x packet |
| tx_sel_i | input | 1 | Transmit start condition select |
| thresh_i | input | LW | FIFO byte threshold |
| tx_en_i | input | 1 | Transmit direction enabled |
| fifo_level_i | input | LW | Bytes held in the FIFO |
| fifo_full_i | input | 1 | FIFO full flag |
| fifo_empty_i | input | 1 | FIFO empty flag |
| shift_done_i | input | 1 | Last bit has left the shift register |
| fill_en_o | output | 1 | FIFO write enable for received data |
| fill_stat_o | output | 1 | Sync-triggered fill in progress |
| tx_start_o | output | 1 | One-cycle transmission start strobe |
| tx_done_o | output | 1 | One-cycle transmit-done interrupt |
| irq0_o | output | 1 | Selected source of interrupt line 0 |

## Verification
All state outputs are registered. fill_en_o and fill_stat_o respond to a sync pulse, clear or control-bit change one clock edge after the cycle in which the input is sampled. tx_start_o and tx_done_o appear one edge after the start condition or the shift-done pulse, and irq0_o follows the FIFO inputs in the same cycle. The bench drives inputs two time units after a rising edge and compares every output with a behavioural model at each falling edge. Directed checks are read just after the next rising edge, so each sample falls exactly in the cycle where the result is due.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    typedef enum logic [1:0] {
        F_ARMED     = 2'd0,
        F_SYNC_FILL = 2'd1,
        F_MAN_STOP  = 2'd2,
        F_MAN_RUN   = 2'd3
    } fill_st_e;

    typedef enum logic {
        T_IDLE = 1'b0,
        T_SEND = 1'b1
    } tx_st_e;

    localparam logic [1:0] DM_CONT = 2'b00;
    localparam logic [1:0] DM_BUF  = 2'b01;
endpackage

// File: rtl/pfc_fill.sv
module pfc_fill
    import pfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_det_i,
    input  logic fill_manual_i,
    input  logic fill_run_i,
    input  logic fill_clr_i,
    input  logic clr_hold_i,
    output logic fill_en_o,
    output logic fill_stat_o
);
    fill_st_e st_q, st_d;
    logic     clr_ok;

    assign clr_ok = fill_clr_i && !clr_hold_i && !sync_det_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= F_ARMED;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            F_ARMED: begin
                if (fill_manual_i)   st_d = F_MAN_STOP;
                else if (sync_det_i) st_d = F_SYNC_FILL;
            end
            F_SYNC_FILL: begin
                if (clr_ok) st_d = F_ARMED;
            end
            F_MAN_STOP: begin
                if (!fill_manual_i)  st_d = F_ARMED;
                else if (fill_run_i) st_d = F_MAN_RUN;
            end
            F_MAN_RUN: begin
                if (!fill_run_i) st_d = F_MAN_STOP;
            end
            default: st_d = F_ARMED;
        endcase
    end

    always_comb begin
        fill_en_o   = 1'b0;
        fill_stat_o = 1'b0;
        unique case (st_q)
            F_SYNC_FILL: begin
                fill_en_o   = 1'b1;
                fill_stat_o = 1'b1;
            end
            F_MAN_RUN: fill_en_o = 1'b1;
            default: ;
        endcase
    end

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_stat_o && fill_clr_i && !clr_hold_i && !sync_det_i) |=> !fill_stat_o); // R3
    AST_CLR_SYNC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_stat_o && fill_clr_i && sync_det_i) |=> fill_stat_o); // R4
    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_stat_o && clr_hold_i) |=> fill_stat_o); // R5
    AST_MAN_NO_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == F_MAN_STOP && fill_manual_i) |=> !fill_stat_o); // R6
endmodule

// File: rtl/pfc_tx.sv
module pfc_tx
    import pfc_pkg::*;
#(
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en_i,
    input  logic [1:0]    mode_i,
    input  logic          tx_sel_i,
    input  logic [LW-1:0] thresh_i,
    input  logic [LW-1:0] fifo_level_i,
    input  logic          fifo_full_i,
    input  logic          fifo_empty_i,
    input  logic          shift_done_i,
    output logic          tx_start_o,
    output logic          tx_done_o,
    output logic          irq0_o
);
    tx_st_e        st_q, st_d;
    logic [1:0]    mode_h;
    logic          sel_h;
    logic [LW-1:0] thr_h;
    logic [1:0]    mode_e;
    logic          sel_e;
    logic [LW-1:0] thr_e;
    logic          thr_flag;
    logic          go;
    logic          start_q, done_q;

    assign mode_e   = (st_q == T_IDLE) ? mode_i   : mode_h;
    assign sel_e    = (st_q == T_IDLE) ? tx_sel_i : sel_h;
    assign thr_e    = (st_q == T_IDLE) ? thresh_i : thr_h;
    assign thr_flag = (fifo_level_i >= thr_e);

    always_comb begin
        go     = 1'b0;
        irq0_o = 1'b0;
        if (mode_e == DM_BUF) begin
            go     = sel_e ? !fifo_empty_i : fifo_full_i;
            irq0_o = !fifo_empty_i;
        end else if (mode_e[1]) begin
            go     = sel_e ? thr_flag : !fifo_empty_i;
            irq0_o = sel_e ? thr_flag : !fifo_empty_i;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            T_IDLE: if (tx_en_i && go) st_d = T_SEND;
            T_SEND: if (shift_done_i)  st_d = T_IDLE;
            default: st_d = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= T_IDLE;
            start_q <= 1'b0;
            done_q  <= 1'b0;
            mode_h  <= DM_CONT;
            sel_h   <= 1'b0;
            thr_h   <= '0;
        end else begin
            st_q    <= st_d;
            start_q <= (st_q == T_IDLE) && (st_d == T_SEND);
            done_q  <= (st_q == T_SEND) && shift_done_i;
            if (st_q == T_IDLE) begin
                mode_h <= mode_i;
                sel_h  <= tx_sel_i;
                thr_h  <= thresh_i;
            end
        end
    end

    assign tx_start_o = start_q;
    assign tx_done_o  = done_q;

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start_o |=> !tx_start_o); // R11
    AST_DONE_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_o |-> $past(shift_done_i)); // R11
    AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == T_SEND && !shift_done_i) |=> !tx_start_o); // R11
    AST_CONT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == T_IDLE && mode_i == DM_CONT) |=> !tx_start_o); // R10
endmodule

// File: rtl/pkt_fifo_ctl.sv
module pkt_fifo_ctl #(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_det_i,
    input  logic          fill_manual_i,
    input  logic          fill_run_i,
    input  logic          fill_clr_i,
    input  logic          clr_hold_i,
    input  logic [1:0]    mode_i,
    input  logic          tx_sel_i,
    input  logic [LW-1:0] thresh_i,
    input  logic          tx_en_i,
    input  logic [LW-1:0] fifo_level_i,
    input  logic          fifo_full_i,
    input  logic          fifo_empty_i,
    input  logic          shift_done_i,
    output logic          fill_en_o,
    output logic          fill_stat_o,
    output logic          tx_start_o,
    output logic          tx_done_o,
    output logic          irq0_o
);
    pfc_fill u_fill (
        .clk           (clk),
        .rst_n         (rst_n),
        .sync_det_i    (sync_det_i),
        .fill_manual_i (fill_manual_i),
        .fill_run_i    (fill_run_i),
        .fill_clr_i    (fill_clr_i),
        .clr_hold_i    (clr_hold_i),
        .fill_en_o     (fill_en_o),
        .fill_stat_o   (fill_stat_o)
    );

    pfc_tx #(.LW(LW)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_en_i      (tx_en_i),
        .mode_i       (mode_i),
        .tx_sel_i     (tx_sel_i),
        .thresh_i     (thresh_i),
        .fifo_level_i (fifo_level_i),
        .fifo_full_i  (fifo_full_i),
        .fifo_empty_i (fifo_empty_i),
        .shift_done_i (shift_done_i),
        .tx_start_o   (tx_start_o),
        .tx_done_o    (tx_done_o),
        .irq0_o       (irq0_o)
    );
endmodule

// File: tb/pkt_fifo_ctl_test.sv
module pkt_fifo_ctl_test;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 16;
    localparam int LW     = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_det = 0, fill_manual = 0, fill_run = 0, fill_clr = 0, clr_hold = 0;
    logic [1:0] mode = 2'b00;
    logic tx_sel = 0, tx_en = 0, shift_done = 0;
    logic [LW-1:0] thresh = '0;
    int   level = 0;
    logic fill_en, fill_stat, tx_start, tx_done, irq0;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int m_fill = 0;       // 0 armed, 1 sync fill, 2 manual stopped, 3 manual running
    bit m_busy = 0, m_start = 0, m_done = 0;
    int m_mode = 0, m_sel = 0, m_thr = 0;

    always #(PERIOD/2) clk = ~clk;

    pkt_fifo_ctl #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .sync_det_i(sync_det), .fill_manual_i(fill_manual),
        .fill_run_i(fill_run), .fill_clr_i(fill_clr), .clr_hold_i(clr_hold),
        .mode_i(mode), .tx_sel_i(tx_sel), .thresh_i(thresh), .tx_en_i(tx_en),
        .fifo_level_i(LW'(level)), .fifo_full_i(level == DEPTH), .fifo_empty_i(level == 0),
        .shift_done_i(shift_done), .fill_en_o(fill_en), .fill_stat_o(fill_stat),
        .tx_start_o(tx_start), .tx_done_o(tx_done), .irq0_o(irq0)
    );

    function automatic bit want_start(int md, int sl, int th);
        if (md == 1) return sl != 0 ? (level != 0) : (level == DEPTH);
        if (md >= 2) return sl != 0 ? (level >= th) : (level != 0);
        return 0;
    endfunction

    function automatic bit want_irq();
        int md, sl, th;
        md = m_busy ? m_mode : int'(mode);
        sl = m_busy ? m_sel  : int'(tx_sel);
        th = m_busy ? m_thr  : int'(thresh);
        if (md == 1) return level != 0;
        if (md >= 2) return sl != 0 ? (level >= th) : (level != 0);
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_fill = 0; m_busy = 0; m_start = 0; m_done = 0;
            m_mode = 0; m_sel = 0; m_thr = 0;
        end else begin
            if (m_fill == 0) begin
                if (fill_manual) m_fill = 2; else if (sync_det) m_fill = 1;
            end else if (m_fill == 1) begin
                if (fill_clr && !clr_hold && !sync_det) m_fill = 0;
            end else if (m_fill == 2) begin
                if (!fill_manual) m_fill = 0; else if (fill_run) m_fill = 3;
            end else begin
                if (!fill_run) m_fill = 2;
            end
            m_done  = m_busy && shift_done;
            m_start = 0;
            if (!m_busy) begin
                m_mode = int'(mode); m_sel = int'(tx_sel); m_thr = int'(thresh);
                if (tx_en && want_start(m_mode, m_sel, m_thr)) begin
                    m_busy = 1; m_start = 1;
                end
            end else if (shift_done) begin
                m_busy = 0;
            end
        end
    end

    task automatic check(input bit act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // continuous comparison against the model at every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(fill_en,   (m_fill == 1 || m_fill == 3), "R2 fill_en model");
            check(fill_stat, (m_fill == 1),                "R3 fill_stat model");
            check(tx_start,  m_start,                      "R11 tx_start model");
            check(tx_done,   m_done,                       "R11 tx_done model");
            check(irq0,      want_irq(),                   "R9 irq0 model");
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        tick(3);
        check(fill_en, 0, "R1"); check(fill_stat, 0, "R1");
        check(tx_start, 0, "R1"); check(tx_done, 0, "R1");
        rst_n = 1;
        tick();
        check(fill_en, 0, "R1"); check(fill_stat, 0, "R1");
        check(tx_start, 0, "R1"); check(tx_done, 0, "R1"); check(irq0, 0, "R1");

        // automatic fill
        sync_det = 1; tick(); sync_det = 0;
        check(fill_en, 1, "R2"); check(fill_stat, 1, "R2");
        clr_hold = 1; fill_clr = 1; tick(); fill_clr = 0; clr_hold = 0;
        check(fill_stat, 1, "R5");
        fill_manual = 1; tick(2);
        check(fill_en, 1, "R7"); check(fill_stat, 1, "R7");
        fill_clr = 1; sync_det = 1; tick(); fill_clr = 0; sync_det = 0;
        check(fill_stat, 1, "R4");
        fill_clr = 1; tick(); fill_clr = 0;
        check(fill_stat, 0, "R3"); check(fill_en, 0, "R3");
        // manual fill
        tick();
        sync_det = 1; tick(); sync_det = 0;
        check(fill_stat, 0, "R6"); check(fill_en, 0, "R6");
        fill_run = 1; tick();
        check(fill_en, 1, "R6"); check(fill_stat, 0, "R6");
        fill_run = 0; tick();
        check(fill_en, 0, "R6");
        fill_manual = 0; tick(2);
        sync_det = 1; tick(); sync_det = 0;
        check(fill_stat, 1, "R2");
        fill_clr = 1; tick(); fill_clr = 0;

        // buffered, start on full
        tx_en = 1; mode = 2'b01; tx_sel = 0; level = 3; tick(3);
        check(tx_start, 0, "R8"); check(irq0, 1, "R8");
        level = DEPTH; tick();
        check(tx_start, 1, "R8");
        tick();
        check(tx_start, 0, "R11");
        tick(3);
        check(tx_start, 0, "R11");
        shift_done = 1; tx_en = 0; tick(); shift_done = 0;
        check(tx_done, 1, "R11");
        tick();
        check(tx_done, 0, "R11"); check(tx_start, 0, "R11");

        // buffered, start on not empty
        level = 0; tx_sel = 1; tx_en = 1; tick();
        check(tx_start, 0, "R8"); check(irq0, 0, "R8");
        level = 1; tick();
        check(tx_start, 1, "R8");
        shift_done = 1; tx_en = 0; tick(); shift_done = 0; tick();

        // packet, threshold start
        mode = 2'b10; tx_sel = 1; thresh = LW'(5); level = 4; tx_en = 1; tick();
        check(tx_start, 0, "R9"); check(irq0, 0, "R9");
        level = 5; tick();
        check(tx_start, 1, "R9"); check(irq0, 1, "R9");
        // settings held while sending
        tx_sel = 0; mode = 2'b00; level = 2; tick();
        check(irq0, 0, "R12");
        mode = 2'b10; shift_done = 1; tx_en = 0; tick(); shift_done = 0;
        check(tx_done, 1, "R11"); check(irq0, 1, "R12");

        // packet, not-empty start
        mode = 2'b11; tx_sel = 0; level = 1; tx_en = 1; tick();
        check(tx_start, 1, "R9");
        shift_done = 1; tx_en = 0; tick(); shift_done = 0; tick();

        // continuous mode: never starts
        mode = 2'b00; level = DEPTH; tx_en = 1; tick(4);
        check(tx_start, 0, "R10"); check(irq0, 0, "R10");
        tx_en = 0; tick(2);
        report();
    end
endmodule